// File: doc/BRIEF.md
# Page-table-entry cache

This block keeps recently used 32-bit translation-table words close to the address-translation walker. The walker presents a physical word address. A valid line holding that address returns its word without a memory access. Any other request goes out on a simple memory read port, and the returned word is passed back to the walker. The cache is direct-mapped, with one word per line. Memory responses come back in request order. Several misses may be in flight at once, up to a limit that software sets.

Software controls the block through three write ports: a configuration word, a flush command word, and a small register that holds the physical address bits above bit 31. The flush command either empties the whole cache or removes every line that falls in one memory atom. That atom is named by a full physical address. Any fill still in flight for a flushed atom completes toward the walker but is not kept.

Top module: `pte_cache`

## Requirements
- R1: After reset no line is valid, the cache is disabled, the outstanding-request limit is 8 and the index map is all ones. No response and no memory request is active.
- R2: While disabled (configuration bit 29 = 0), every walker request goes to memory and returns the memory word. A repeated request goes to memory again.
- R3: While enabled, a request with no valid line holding its address issues one memory read and returns the memory word. The line is then allocated, and a later request to the same address is answered without a memory read.
- R4: The line index is the low index bits of the word address ANDed with configuration bits [5:0]. With a map of zero, all addresses share line 0.
- R5: Configuration bits [27:24] set the maximum number of memory reads in flight, and a value of 0 acts as 1. When the limit is reached, a missing request is held off (req_ready low) until a response returns.
- R6: Responses reach the walker in request order. A request that would hit is held off while any memory read is outstanding.
- R7: A flush write with bit 0 = 0 invalidates every line.
- R8: A flush write with bit 0 = 1 invalidates every line whose word lies in the same ATOM_BYTES-aligned atom as the byte address. That address is formed from the high-bits register above the 32-bit flush word, with the low bits rounded down to the atom.
- R9: The high-bits register is written separately, before the flush, and keeps its value for later flushes until it is rewritten.
- R10: A flush that covers a fill still in flight lets the word reach the walker but does not allocate it. The next request to that address goes to memory.
- R11: Two addresses with the same index evict each other, so alternating between them always misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Walker request present |
| req_ready | output | 1 | Walker request accepted this cycle |
| req_addr | input | PA_W-2 | Physical word address |
| resp_valid | output | 1 | Word returned to walker |
| resp_data | output | 32 | Returned word |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | PA_W-2 | Memory word address |
| mem_resp_valid | input | 1 | Memory word returned, in order |
| mem_resp_data | input | 32 | Memory word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Bit 29 enable, [27:24] limit, [5:0] index map |
| flush_hi_wr | input | 1 | High-address register write strobe |
| flush_hi_wdata | input | PA_W-32 | Physical address bits above 31 |
| flush_wr | input | 1 | Flush command strobe |
| flush_wdata | input | 32 | Bit 0 type; the whole word is the low byte address |

## Verification
The assertions assume that memory never returns a word without an outstanding read and never returns words out of order. The bench memory model enforces both: it is a fixed-latency pipeline that returns a word only for each accepted request. The assertions also assume that no more than 15 reads are ever in flight. The 4-bit limit field keeps this true, and the random phase draws limits only from that field. Random addresses come from a small pool spread across all four high-bit values, so hits, conflicts and atom flushes all occur often.

// File: rtl/pte_cache.sv
module pte_cache #(
  parameter int PA_W       = 34,
  parameter int IDX_W      = 4,
  parameter int ATOM_BYTES = 32,
  parameter int RST_LIMIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-3:0]   req_addr,
  output logic              resp_valid,
  output logic [31:0]       resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-3:0]   mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [31:0]       mem_resp_data,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              flush_hi_wr,
  input  logic [PA_W-33:0]  flush_hi_wdata,
  input  logic              flush_wr,
  input  logic [31:0]       flush_wdata
);
  localparam int WA_W  = PA_W - 2;
  localparam int LINES = 1 << IDX_W;
  localparam int A_LG  = $clog2(ATOM_BYTES);
  localparam int W_SH  = A_LG - 2;
  localparam int AT_W  = PA_W - A_LG;
  localparam int PEND  = 16;
  localparam int HI_W  = PA_W - 32;

  logic             cfg_en;
  logic [3:0]       cfg_lim;
  logic [5:0]       cfg_map;
  logic [HI_W-1:0]  hi_q;
  logic [LINES-1:0] line_v;
  logic [WA_W-1:0]  line_a [LINES];
  logic [31:0]      line_d [LINES];
  logic [WA_W-1:0]  pend_a [PEND];
  logic [IDX_W-1:0] pend_i [PEND];
  logic [PEND-1:0]  pend_k;
  logic [3:0]       wp, rp;
  logic [4:0]       out_cnt;

  logic [3:0]       eff_lim;
  logic [IDX_W-1:0] idx;
  logic             hit, can_miss, acc_hit, push, pop, fl_all, fl_adr, keep_fill;
  logic [PA_W-1:0]  fl_byte;
  logic [AT_W-1:0]  fl_atom;

  assign eff_lim  = (cfg_lim == 4'd0) ? 4'd1 : cfg_lim;
  assign idx      = req_addr[IDX_W-1:0] & cfg_map[IDX_W-1:0];
  assign hit      = cfg_en && line_v[idx] && (line_a[idx] == req_addr);
  assign can_miss = out_cnt < {1'b0, eff_lim};
  assign mem_req_valid = req_valid && !hit && can_miss;
  assign mem_req_addr  = req_addr;
  assign req_ready = hit ? (out_cnt == 5'd0) : (can_miss && mem_req_ready);
  assign acc_hit  = req_valid && hit && (out_cnt == 5'd0);
  assign push     = mem_req_valid && mem_req_ready;
  assign pop      = mem_resp_valid;
  assign fl_all   = flush_wr && !flush_wdata[0];
  assign fl_adr   = flush_wr && flush_wdata[0];
  assign fl_byte  = {hi_q, flush_wdata};
  assign fl_atom  = fl_byte[PA_W-1:A_LG];

  function automatic logic killed(input logic [WA_W-1:0] w);
    return fl_all || (fl_adr && (w[WA_W-1:W_SH] == fl_atom));
  endfunction

  assign keep_fill = pop && pend_k[rp] && cfg_en && !killed(pend_a[rp]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en     <= 1'b0;
      cfg_lim    <= 4'(RST_LIMIT);
      cfg_map    <= '1;
      hi_q       <= '0;
      line_v     <= '0;
      pend_k     <= '0;
      wp         <= '0;
      rp         <= '0;
      out_cnt    <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_en  <= cfg_wdata[29];
        cfg_lim <= cfg_wdata[27:24];
        cfg_map <= cfg_wdata[5:0];
      end
      if (flush_hi_wr) hi_q <= flush_hi_wdata;
      resp_valid <= acc_hit || pop;
      if (acc_hit) resp_data <= line_d[idx];
      else if (pop) resp_data <= mem_resp_data;
      for (int i = 0; i < LINES; i++)
        if (killed(line_a[i])) line_v[i] <= 1'b0;
      for (int j = 0; j < PEND; j++)
        if (killed(pend_a[j])) pend_k[j] <= 1'b0;
      if (push) begin
        pend_k[wp] <= cfg_en && !killed(req_addr);
        wp <= wp + 4'd1;
      end
      if (pop) rp <= rp + 4'd1;
      if (keep_fill) line_v[pend_i[rp]] <= 1'b1;
      out_cnt <= out_cnt + {4'd0, push} - {4'd0, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      pend_a[wp] <= req_addr;
      pend_i[wp] <= idx;
    end
    if (keep_fill) begin
      line_a[pend_i[rp]] <= pend_a[rp];
      line_d[pend_i[rp]] <= mem_resp_data;
    end
  end

  p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_wr && !flush_wdata[0]) |=> (line_v == '0));
  p_no_alloc_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> ((line_v & ~$past(line_v)) == '0));
  p_out_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= 5'd15);
  p_resp_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_resp_valid |-> (out_cnt != 5'd0));
  p_resp_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(acc_hit) || $past(mem_resp_valid)));
endmodule

// File: tb/pte_cache_bench.sv
module pte_cache_bench;
  localparam int LAT = 12;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, resp_valid, mem_req_valid, mem_resp_valid;
  logic [31:0] req_addr = 0, resp_data, mem_req_addr, mem_resp_data;
  logic mem_req_ready = 1;
  logic cfg_wr = 0, flush_hi_wr = 0, flush_wr = 0;
  logic [31:0] cfg_wdata = 0, flush_wdata = 0;
  logic [1:0] flush_hi_wdata = 0;

  always #2.5 clk = ~clk;

  pte_cache u_pte_cache (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .flush_hi_wr(flush_hi_wr), .flush_hi_wdata(flush_hi_wdata),
    .flush_wr(flush_wr), .flush_wdata(flush_wdata));

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  logic        pv [LAT];
  logic [31:0] pa [LAT];
  int nreq = 0, nresp = 0;
  assign mem_resp_valid = pv[LAT-1];
  assign mem_resp_data  = memf(pa[LAT-1]);
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= mem_req_valid && mem_req_ready;
      pa[0] <= mem_req_addr;
      for (int k = 1; k < LAT; k++) begin pv[k] <= pv[k-1]; pa[k] <= pa[k-1]; end
      if (mem_req_valid && mem_req_ready) nreq <= nreq + 1;
      if (mem_resp_valid) nresp <= nresp + 1;
    end
  end

  logic [31:0] expq [256];
  logic [7:0] ewr = 0, erd = 0;
  int mon_checks = 0, mon_fails = 0;
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      mon_checks <= mon_checks + 1;
      if (erd == ewr) begin
        mon_fails <= mon_fails + 1;
        $display("FAIL R6 unexpected response: got %h expected none", resp_data);
      end else begin
        if (resp_data !== memf(expq[erd])) begin
          mon_fails <= mon_fails + 1;
          $display("FAIL R3/R6 data for %h: got %h expected %h", expq[erd], resp_data, memf(expq[erd]));
        end
        erd <= erd + 8'd1;
      end
    end
  end

  int checks = 0, fails = 0, max_out = 0;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, ex);
    end
  endtask

  task automatic upd_max();
    if (nreq - nresp > max_out) max_out = nreq - nresp;
  endtask

  task automatic issue(input logic [31:0] a, output bit went);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    #1;
    while (!req_ready) begin upd_max(); @(negedge clk); #1; end
    went = mem_req_valid;
    expq[ewr] = a; ewr = ewr + 8'd1;
    upd_max();
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (nreq != nresp || erd != ewr) begin upd_max(); @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic access(input logic [31:0] a, input bit exp_mem, input string rq);
    bit w;
    issue(a, w); drain();
    chk(w == exp_mem, rq, $sformatf("memory read for %h", a), w, exp_mem);
  endtask

  task automatic cfg(input bit en, input logic [3:0] lim, input logic [5:0] map);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = {2'b0, en, 1'b0, lim, 18'b0, map};
    @(posedge clk); #1 cfg_wr = 0;
  endtask

  task automatic set_hi(input logic [1:0] hi);
    @(negedge clk);
    flush_hi_wr = 1; flush_hi_wdata = hi;
    @(posedge clk); #1 flush_hi_wr = 0;
  endtask

  task automatic flush(input logic [31:0] w);
    @(negedge clk);
    flush_wr = 1; flush_wdata = w;
    @(posedge clk); #1 flush_wr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks + 1, fails + mon_fails + 1);
    $finish;
  end

  initial begin
    bit w;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);
    chk(mem_req_valid == 0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
    // R1/R2: disabled by default, every access goes to memory
    access(32'h40, 1, "R2");
    access(32'h40, 1, "R2");
    // R1/R5: default limit 8
    max_out = 0;
    for (int i = 0; i < 12; i++) issue(32'h80 + i, w);
    drain();
    chk(max_out == 8, "R5", "in flight with reset limit", max_out, 8);
    // R3: allocate then hit
    cfg(1, 4'd8, 6'h3f);
    access(32'h55, 1, "R3");
    access(32'h55, 0, "R3");
    // R5: limit 2 then limit 0 acting as 1
    cfg(1, 4'd2, 6'h3f); max_out = 0;
    for (int i = 0; i < 6; i++) issue(32'h1000 + i, w);
    drain();
    chk(max_out == 2, "R5", "in flight with limit 2", max_out, 2);
    cfg(1, 4'd0, 6'h3f); max_out = 0;
    for (int i = 0; i < 5; i++) issue(32'h2000 + i, w);
    drain();
    chk(max_out == 1, "R5", "in flight with limit 0", max_out, 1);
    // R6: hit held behind outstanding miss
    cfg(1, 4'd8, 6'h3f);
    access(32'h61, 1, "R6");
    issue(32'h72, w);
    issue(32'h61, w);
    chk(w == 0, "R6", "hit needs no memory read", w, 0);
    chk(nreq == nresp, "R6", "hit accepted with reads in flight", nreq - nresp, 0);
    drain();
    // R4: index map
    flush(32'h0);
    cfg(1, 4'd8, 6'h00);
    access(32'h10, 1, "R4"); access(32'h11, 1, "R4"); access(32'h10, 1, "R4");
    flush(32'h0);
    cfg(1, 4'd8, 6'h3f);
    access(32'h10, 1, "R4"); access(32'h11, 1, "R4"); access(32'h10, 0, "R4");
    // R11: conflict eviction
    access(32'h20, 1, "R11"); access(32'h30, 1, "R11"); access(32'h20, 1, "R11");
    // R7: flush all
    access(32'h33, 1, "R7"); access(32'h33, 0, "R7");
    flush(32'h0);
    access(32'h33, 1, "R7");
    // R8: atom flush
    set_hi(2'd0);
    access(32'h100, 1, "R8"); access(32'h101, 1, "R8"); access(32'h108, 1, "R8");
    flush(32'h40D);
    access(32'h108, 0, "R8"); access(32'h100, 1, "R8"); access(32'h101, 1, "R8");
    // R9: high bits come from separate register and persist
    access(32'hC000_0200, 1, "R9");
    flush(32'h801);
    access(32'hC000_0200, 0, "R9");
    set_hi(2'd3);
    flush(32'h801);
    access(32'hC000_0200, 1, "R9");
    access(32'hC000_0300, 1, "R9");
    flush(32'hC01);
    access(32'hC000_0300, 1, "R9");
    // R10: flush during a fill
    set_hi(2'd0);
    issue(32'h240, w);
    flush(32'h901);
    drain();
    access(32'h240, 1, "R10");
    access(32'h240, 0, "R10");
    // random phase, data and order checked by the monitor
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 100;
      if (op < 80) begin
        issue(($urandom % 64) | (($urandom % 4) << 30), w);
        if ($urandom % 4 == 0) drain();
      end else if (op < 88) flush(($urandom % 1024) << 2 | ($urandom % 2));
      else if (op < 94) set_hi(2'($urandom % 4));
      else cfg(1'($urandom % 2), 4'($urandom % 16), 6'($urandom % 64));
    end
    drain();
    chk(erd == ewr, "R6", "all responses delivered", erd, ewr);
    $display("== %0d vectors applied, %0d miscompares ==", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule